// File: doc/BRIEF.md
# Space-Coded Four-Level Bus Encoder

This block sits in the transmit path of a parallel chip-to-chip link that drives four-level pulse amplitude signals. On each clock cycle it accepts a data word with a valid strobe. It spreads the word over a group of bus lines and gives each line a 2-bit level code. A small convolutional code protects the bits that pick the level subset. The code runs across the lines of one word, not along time. The analog drivers downstream turn each 2-bit code into one of four voltage levels.

The four levels split into two subsets. In each subset the two members are twice as far apart as neighbouring levels in the full set. Each line symbol therefore carries two bits:

- A pick bit chooses the lower or upper member of the subset.
- A subset bit comes from a two-state code that takes the XOR of two adjacent path bits.

The code starts in state zero at the first line and is driven back to state zero at the last line. Because of this, the last line carries no free path bit, and no state passes from one word to the next.

The group size is a parameter:

- With three lines, the block packs 5 data bits into 6 coded bits.
- With four lines, it packs 7 data bits into 8 coded bits.

Outputs are registered with one cycle of latency.

Top module: `pam4_space_encoder`

## Requirements
- R1: During and after reset, until the first accepted word, `out_valid` is 0 and `out_sym` is all zeros.
- R2: `out_valid` equals `in_valid` from the previous clock cycle.
- R3: Line k (k = 1..LINES) occupies `out_sym[2k-1:2k-2]`. Its level code is {pick, subset}, and codes mean 00=-3, 01=-1, 10=+1, 11=+3. Subset 0 is {-3,+1}, subset 1 is {-1,+3}, and the pick bit selects the upper member. The pick bit of line k is `in_data[k-1]`.
- R4: The path bits are u1..u(LINES-1), with uj = `in_data[LINES+j-1]`. The subset bit of line 1 equals u1.
- R5: The subset bit of an interior line k (1 < k < LINES) equals u(k-1) XOR uk.
- R6: The subset bit of the last line equals u(LINES-1), which returns the code to state zero. The last line has no path bit of its own.
- R7: Whenever `out_valid` is 1, the XOR of all subset bits in `out_sym` is 0.
- R8: The symbols for a word depend only on that word, not on any word accepted earlier.
- R9: When `in_valid` is 0, `out_sym` keeps its previous value on the next cycle.
- R10: With LINES=4 the block takes 7 data bits and produces four line codes by the same rules: s1=u1, s2=u1^u2, s3=u2^u3, s4=u3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Data word strobe |
| in_data | input | 2*LINES-1 | {path bits, pick bits}, with pick bits in the low LINES positions |
| out_valid | output | 1 | Registered strobe |
| out_sym | output | 2*LINES | Level codes, line 1 in the low two bits |

## Verification
The only state in this block is the output register. A wrong internal value shows up at the ports one cycle after the word it belongs to, as a wrong level code on a single line.

- An error in the subset path breaks the even parity of the subset bits within that same cycle.
- A broken hold shows up as codes that change while the strobe is low.
- Leakage of state between words shows up as two different results for one repeated word.

Every word is compared against a model built from the requirements, so each of these faults is caught on the first affected output cycle.

// File: rtl/pam4_space_encoder.sv
module pam4_space_encoder #(
  parameter int LINES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [2*LINES-2:0]   in_data,
  output logic                 out_valid,
  output logic [2*LINES-1:0]   out_sym
);

  localparam int DW = 2*LINES-1;
  localparam int SW = 2*LINES;

  logic [LINES:0]   path;
  logic [LINES-1:0] pick;
  logic [LINES-1:0] subset;
  logic [SW-1:0]    next_sym;
  logic [LINES-1:0] out_subset;
  logic [LINES-1:0] out_pick;

  assign path = {1'b0, in_data[DW-1:LINES], 1'b0};
  assign pick = in_data[LINES-1:0];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign subset[i]        = path[i] ^ path[i+1];
    assign next_sym[2*i+:2] = {pick[i], subset[i]};
    assign out_subset[i]    = out_sym[2*i];
    assign out_pick[i]      = out_sym[2*i+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sym <= next_sym;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)) else $error("valid"); // R2

  AST_PICK_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_pick == $past(in_data[LINES-1:0])) else $error("pick"); // R3

  AST_FIRST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_subset[0] == $past(in_data[LINES])) else $error("first"); // R4

  AST_LAST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_subset[LINES-1] == $past(in_data[DW-1])) else $error("last"); // R6

  AST_EVEN_SUBSETS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (^out_subset) == 1'b0) else $error("parity"); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sym)) else $error("hold"); // R9

endmodule

// File: tb/pam4_space_encoder_test.sv
`timescale 1ns/1ps
module pam4_space_encoder_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v3 = 1'b0, v4 = 1'b0;
  logic [4:0] d3 = '0;
  logic [6:0] d4 = '0;
  logic ov3, ov4;
  logic [5:0] s3;
  logic [7:0] s4;

  int applied = 0;
  int bad = 0;
  bit running = 1'b0;

  logic [6:0] q3[$];
  logic [8:0] q4[$];
  logic [5:0] hold3 = '0;
  logic [7:0] hold4 = '0;

  always #2 clk = ~clk;

  pam4_space_encoder #(.LINES(3)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(v3), .in_data(d3),
    .out_valid(ov3), .out_sym(s3));

  pam4_space_encoder #(.LINES(4)) uut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(v4), .in_data(d4),
    .out_valid(ov4), .out_sym(s4));

  function automatic logic [5:0] ref3(input logic [4:0] w);
    logic u1, u2;
    u1 = w[3]; u2 = w[4];
    return {w[2], u2, w[1], u1 ^ u2, w[0], u1};
  endfunction

  function automatic logic [7:0] ref4(input logic [6:0] w);
    logic u1, u2, u3;
    u1 = w[4]; u2 = w[5]; u3 = w[6];
    return {w[3], u3, w[2], u2 ^ u3, w[1], u1 ^ u2, w[0], u1};
  endfunction

  task automatic step(input logic v, input logic [6:0] w);
    @(negedge clk);
    v3 = v; d3 = w[4:0];
    v4 = v; d4 = w;
    if (v) begin
      hold3 = ref3(w[4:0]);
      hold4 = ref4(w);
    end
    q3.push_back({v, hold3});
    q4.push_back({v, hold4});
  endtask

  always @(posedge clk) begin
    #1;
    if (running && q3.size() > 0) begin
      logic [6:0] e3;
      logic [8:0] e4;
      e3 = q3.pop_front();
      e4 = q4.pop_front();
      applied++;
      if (ov3 !== e3[6]) begin
        bad++;
        $display("FAIL R2/R9 valid got %0b exp %0b", ov3, e3[6]);
      end else if (s3 !== e3[5:0]) begin
        bad++;
        if (s3[1] !== e3[1] || s3[3] !== e3[3] || s3[5] !== e3[5])
          $display("FAIL R3 pick bits got %b exp %b", s3, e3[5:0]);
        else if (s3[0] !== e3[0])
          $display("FAIL R4 line1 subset got %b exp %b", s3, e3[5:0]);
        else if (s3[2] !== e3[2])
          $display("FAIL R5 interior subset got %b exp %b", s3, e3[5:0]);
        else
          $display("FAIL R6 last subset got %b exp %b", s3, e3[5:0]);
        if (!e3[6]) $display("FAIL R9 hold got %b exp %b", s3, e3[5:0]);
      end
      applied++;
      if (ov3 && ((s3[0] ^ s3[2] ^ s3[4]) !== 1'b0)) begin
        bad++;
        $display("FAIL R7 subset parity got %b exp 0", s3[0] ^ s3[2] ^ s3[4]);
      end
      applied++;
      if (ov4 !== e4[8] || s4 !== e4[7:0]) begin
        bad++;
        $display("FAIL R10 wide got %0b/%b exp %0b/%b", ov4, s4, e4[8], e4[7:0]);
      end
    end
  end

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog got hang exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    logic [5:0] first_a;
    repeat (3) @(negedge clk);
    applied++;
    if (ov3 !== 1'b0 || s3 !== '0 || ov4 !== 1'b0 || s4 !== '0) begin
      bad++;
      $display("FAIL R1 reset got %0b/%b exp 0/000000", ov3, s3);
    end
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    // R1: no output before the first accepted word
    @(negedge clk);
    applied++;
    if (ov3 !== 1'b0 || s3 !== '0) begin
      bad++;
      $display("FAIL R1 post-reset got %0b/%b exp 0/000000", ov3, s3);
    end
    // R3 R4 R5 R6 R10: every word back to back
    for (int w = 0; w < 128; w++) step(1'b1, w[6:0]);
    // R9: gaps with hold
    for (int k = 0; k < 200; k++) step(k[0] ^ k[2], 7'($urandom));
    for (int k = 0; k < 300; k++) step(($urandom % 3) != 0, 7'($urandom));
    step(1'b0, 7'h00);
    // R8: same word after different predecessors
    step(1'b1, 7'h1f);
    step(1'b1, 7'h09);
    @(negedge clk);
    first_a = s3;
    step(1'b1, 7'h00);
    step(1'b1, 7'h09);
    @(negedge clk);
    applied++;
    if (s3 !== first_a) begin
      bad++;
      $display("FAIL R8 repeat word got %b exp %b", s3, first_a);
    end
    step(1'b0, 7'h00);
    repeat (3) @(negedge clk);
    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule